// File: doc/BRIEF.md
# Latched Fault Monitor with Persistence Filter

This block watches the digitized outputs of external comparators for a two-channel bridge power stage and raises a single warning when a fault has been present long enough to be trusted. Each channel supplies two overcurrent bits: one that is high while the supply-side current sense sits below its trip level, and one that is high while the ground-side sense sits above its trip level. A single temperature bit, shared by both channels, is high while the thermal sense node is above its trip level. A condition counts as a fault only after it has held without a break for `FILT` clock cycles (40 cycles by default, about 0.4 µs at 100 MHz). Shorter bursts, such as switching spikes, are discarded and the count starts again from zero.

A qualified fault sets the combined warning and a per-source status bit (left overcurrent, right overcurrent, thermal). All of them are sticky. They stay high after the condition goes away and clear only through the sleep level or power-on reset. Sleep also holds them low for as long as it is asserted. The mode levels gate the sources differently. Mute or sleep stops overcurrent detection. Only sleep stops thermal detection, so it keeps running while the stage is muted. The block only reports: turning off the bridge is left to whatever consumes the warning, for example a mute request fed back from it.

Top module: `fault_guard`

## Requirements
- R1: After power-on reset (`rst_n` low, then released) `warn_o`, both bits of `oc_flag_o` and `temp_flag_o` are 0.
- R2: When `oc_hs_low_i[c]` is high with mute and sleep low for `FILT` consecutive clock edges, `oc_flag_o[c]` and `warn_o` are high right after the `FILT`-th of those edges and not before. Index 0 is the left channel and index 1 is the right channel.
- R3: The same holds for `oc_ls_high_i[c]`, the ground-side overcurrent bit of channel c.
- R4: A raw input that stays high for `FILT-1` edges or fewer and then goes low sets nothing. The next run must again last a full `FILT` edges.
- R5: `temp_high_i` held high with sleep low for `FILT` consecutive edges sets `temp_flag_o` and `warn_o`.
- R6: Once set, a status bit and `warn_o` stay high after the raw input returns low, for as long as sleep stays low.
- R7: On every edge at which `sleep_i` is high, all status bits and `warn_o` are cleared, and they stay low while sleep remains high, whatever the raw inputs do.
- R8: While `mute_i` is high, the overcurrent inputs have no effect and their persistence counts restart. After mute falls, a held input needs a full `FILT` edges to qualify.
- R9: While `mute_i` is high and sleep is low, thermal detection keeps working as in R5.
- R10: Thermal cycles seen while sleep is high do not count. After sleep falls, a held `temp_high_i` needs a full `FILT` edges to qualify.
- R11: Each channel's status bit is set only by its own inputs, and `warn_o` equals the OR of all status bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low, asserted asynchronously and released synchronously inside the block |
| sleep_i | input | 1 | Sleep level (synchronized): clears and holds clear all flags and gates all detection |
| mute_i | input | 1 | Mute level (synchronized): gates overcurrent detection only |
| oc_hs_low_i | input | NCH | Per channel: supply-side sense below threshold (bit 0 left, bit 1 right) |
| oc_ls_high_i | input | NCH | Per channel: ground-side sense above threshold (bit 0 left, bit 1 right) |
| temp_high_i | input | 1 | Shared thermal node above threshold |
| warn_o | output | 1 | Sticky combined warning |
| oc_flag_o | output | NCH | Sticky per-channel overcurrent status |
| temp_flag_o | output | 1 | Sticky thermal status |

## Verification
The assertions assume that the comparator bits and the two mode levels are already synchronous to `clk` and change only between edges. They also assume that the internal reset is released before any raw input is driven high. The bench meets both assumptions: it changes every input at the falling edge, keeps all of them low across reset and the synchronizer's release cycles, and steps through mode changes one clock at a time.

// File: rtl/fg_pkg.sv
package fg_pkg;
  localparam int unsigned CH_LEFT  = 0;
  localparam int unsigned CH_RIGHT = 1;

  // Counter width for a persistence filter of the given length.
  function automatic int unsigned filt_cw(input int unsigned filt);
    return (filt > 2) ? $clog2(filt) : 1;
  endfunction
endpackage

// File: rtl/fg_rst_sync.sv
module fg_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rst_sync_n = sh_q[STAGES-1];
endmodule

// File: rtl/fg_persist.sv
module fg_persist
  import fg_pkg::*;
#(
  parameter int unsigned FILT = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic raw_i,
  output logic hit_o
);
  localparam int unsigned CW  = filt_cw(FILT);
  localparam int unsigned TOP = (FILT > 1) ? FILT - 1 : 0;

  logic live;
  assign live = en_i & raw_i;

  generate
    if (FILT <= 1) begin : g_direct
      assign hit_o = live;
    end else begin : g_count
      logic [CW-1:0] cnt_q;
      logic [CW-1:0] cnt_d;
      logic          cnt_ce;
      logic          at_top;

      assign at_top = (cnt_q == CW'(TOP));

      always_comb begin
        cnt_ce = 1'b0;
        cnt_d  = cnt_q;
        if (!live) begin
          cnt_ce = (cnt_q != '0);
          cnt_d  = '0;
        end else if (!at_top) begin
          cnt_ce = 1'b1;
          cnt_d  = cnt_q + CW'(1);
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt_q <= '0;
        else if (cnt_ce) cnt_q <= cnt_d;
      end

      assign hit_o = live & at_top;

      // R4: a break in the run restarts the count
      p_run_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !live |=> (cnt_q == '0));
      // R4: the count never passes the qualify point
      p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(TOP));
    end
  endgenerate
endmodule

// File: rtl/fg_latch.sv
module fg_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  logic q_q;
  logic q_d;
  logic q_ce;

  always_comb begin
    q_ce = clr_i | set_i;
    q_d  = clr_i ? 1'b0 : 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q_q <= 1'b0;
    else if (q_ce) q_q <= q_d;
  end

  assign q_o = q_q;

  // R7: clear wins over set
  p_clear_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> !q_o);
  // R6: held until cleared
  p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (q_o && !clr_i) |=> q_o);
endmodule

// File: rtl/fault_guard.sv
module fault_guard
  import fg_pkg::*;
#(
  parameter int unsigned NCH  = 2,
  parameter int unsigned FILT = 40
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           sleep_i,
  input  logic           mute_i,
  input  logic [NCH-1:0] oc_hs_low_i,
  input  logic [NCH-1:0] oc_ls_high_i,
  input  logic           temp_high_i,
  output logic           warn_o,
  output logic [NCH-1:0] oc_flag_o,
  output logic           temp_flag_o
);
  logic           rst_q_n;
  logic           oc_en;
  logic           tmp_en;
  logic [NCH-1:0] hs_hit;
  logic [NCH-1:0] ls_hit;
  logic [NCH-1:0] oc_set;
  logic           tmp_hit;
  logic           any_set;

  fg_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_q_n)
  );

  // Mode gating: overcurrent needs both modes idle, thermal only needs sleep idle.
  assign oc_en  = ~mute_i & ~sleep_i;
  assign tmp_en = ~sleep_i;

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_ch
      fg_persist #(.FILT(FILT)) u_hs (
        .clk   (clk),
        .rst_n (rst_q_n),
        .en_i  (oc_en),
        .raw_i (oc_hs_low_i[c]),
        .hit_o (hs_hit[c])
      );

      fg_persist #(.FILT(FILT)) u_ls (
        .clk   (clk),
        .rst_n (rst_q_n),
        .en_i  (oc_en),
        .raw_i (oc_ls_high_i[c]),
        .hit_o (ls_hit[c])
      );

      assign oc_set[c] = hs_hit[c] | ls_hit[c];

      fg_latch u_oc (
        .clk   (clk),
        .rst_n (rst_q_n),
        .set_i (oc_set[c]),
        .clr_i (sleep_i),
        .q_o   (oc_flag_o[c])
      );

      // R2/R3: a channel flag rises only after its own input was live
      p_oc_source_r2: assert property (@(posedge clk) disable iff (!rst_q_n)
        $rose(oc_flag_o[c]) |-> $past(oc_en && (oc_hs_low_i[c] || oc_ls_high_i[c])));
      // R8: mute blocks any new overcurrent flag
      p_mute_gates_oc_r8: assert property (@(posedge clk) disable iff (!rst_q_n)
        mute_i |=> !$rose(oc_flag_o[c]));
    end
  endgenerate

  fg_persist #(.FILT(FILT)) u_tmp (
    .clk   (clk),
    .rst_n (rst_q_n),
    .en_i  (tmp_en),
    .raw_i (temp_high_i),
    .hit_o (tmp_hit)
  );

  fg_latch u_tmp_flag (
    .clk   (clk),
    .rst_n (rst_q_n),
    .set_i (tmp_hit),
    .clr_i (sleep_i),
    .q_o   (temp_flag_o)
  );

  assign any_set = (|oc_set) | tmp_hit;

  fg_latch u_warn (
    .clk   (clk),
    .rst_n (rst_q_n),
    .set_i (any_set),
    .clr_i (sleep_i),
    .q_o   (warn_o)
  );

  // R5/R10: thermal flag rises only from a live input outside sleep
  p_temp_source_r10: assert property (@(posedge clk) disable iff (!rst_q_n)
    $rose(temp_flag_o) |-> $past(temp_high_i && !sleep_i));
  // R11: combined warning tracks the status bits
  p_warn_is_or_r11: assert property (@(posedge clk) disable iff (!rst_q_n)
    warn_o == ((|oc_flag_o) | temp_flag_o));
  // R7: sleep leaves nothing set
  p_sleep_clears_r7: assert property (@(posedge clk) disable iff (!rst_q_n)
    sleep_i |=> (!warn_o && oc_flag_o == '0 && !temp_flag_o));
endmodule

// File: tb/fault_guard_tb_top.sv
`timescale 1ns/1ps
module fault_guard_tb_top;
  localparam int unsigned NCH  = 2;
  localparam int unsigned FILT = 6;

  logic           clk;
  logic           rst_n;
  logic           sleep_i;
  logic           mute_i;
  logic [NCH-1:0] oc_hs_low_i;
  logic [NCH-1:0] oc_ls_high_i;
  logic           temp_high_i;
  logic           warn_o;
  logic [NCH-1:0] oc_flag_o;
  logic           temp_flag_o;

  fault_guard #(.NCH(NCH), .FILT(FILT)) dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .sleep_i      (sleep_i),
    .mute_i       (mute_i),
    .oc_hs_low_i  (oc_hs_low_i),
    .oc_ls_high_i (oc_ls_high_i),
    .temp_high_i  (temp_high_i),
    .warn_o       (warn_o),
    .oc_flag_o    (oc_flag_o),
    .temp_flag_o  (temp_flag_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int unsigned n_run;
  int unsigned n_fail;
  bit          done;
  string       cur_req;

  // expected item {warn, oc[1:0], temp}
  logic [3:0] exp_q[$];
  string      tag_q[$];

  // bench model state: sources 0..3 = hsL, lsL, hsR, lsR; 4 = temp
  int unsigned m_cnt[5];
  logic        m_oc[NCH];
  logic        m_tmp;
  logic        m_warn;

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: {warn,oc,temp} actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  // Monitor: compares one expected item per clock, 1 ns after the edge.
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      check(tag_q.pop_front(), {warn_o, oc_flag_o, temp_flag_o}, exp_q.pop_front());
    end
  end

  // Driver: one clock of stimulus; pushes the state expected after the next edge.
  task automatic cyc(input logic [1:0] hs, input logic [1:0] ls, input logic tmp,
                     input logic slp, input logic mt);
    logic raw [5];
    logic hit [5];
    logic ocen;
    @(negedge clk);
    oc_hs_low_i  = hs;
    oc_ls_high_i = ls;
    temp_high_i  = tmp;
    sleep_i      = slp;
    mute_i       = mt;
    raw[0] = hs[0]; raw[1] = ls[0]; raw[2] = hs[1]; raw[3] = ls[1]; raw[4] = tmp;
    ocen = !mt && !slp;
    for (int s = 0; s < 5; s++) begin
      logic en;
      en = (s < 4) ? ocen : !slp;
      hit[s] = 1'b0;
      if (raw[s] && en) begin
        hit[s] = (m_cnt[s] == FILT - 1);
        if (m_cnt[s] < FILT - 1) m_cnt[s]++;
      end else begin
        m_cnt[s] = 0;
      end
    end
    if (slp) begin
      m_oc[0] = 1'b0; m_oc[1] = 1'b0; m_tmp = 1'b0; m_warn = 1'b0;
    end else begin
      if (hit[0] || hit[1]) m_oc[0] = 1'b1;
      if (hit[2] || hit[3]) m_oc[1] = 1'b1;
      if (hit[4]) m_tmp = 1'b1;
      if (hit[0] || hit[1] || hit[2] || hit[3] || hit[4]) m_warn = 1'b1;
    end
    exp_q.push_back({m_warn, m_oc[1], m_oc[0], m_tmp});
    tag_q.push_back(cur_req);
  endtask

  task automatic hold(input int n, input logic [1:0] hs, input logic [1:0] ls,
                      input logic tmp, input logic slp, input logic mt);
    for (int i = 0; i < n; i++) cyc(hs, ls, tmp, slp, mt);
  endtask

  task automatic drain();
    repeat (2) @(posedge clk);
    #2;
  endtask

  initial begin
    n_run = 0; n_fail = 0; done = 0;
    for (int s = 0; s < 5; s++) m_cnt[s] = 0;
    m_oc[0] = 0; m_oc[1] = 0; m_tmp = 0; m_warn = 0;
    rst_n = 1'b0; sleep_i = 0; mute_i = 0;
    oc_hs_low_i = '0; oc_ls_high_i = '0; temp_high_i = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    check("R1", {warn_o, oc_flag_o, temp_flag_o}, 4'b0000);
    cur_req = "R1";
    hold(2, 2'b00, 2'b00, 0, 0, 0);

    // R4: runs one short of the filter on every source, separated by gaps
    cur_req = "R4";
    hold(FILT-1, 2'b01, 2'b00, 0, 0, 0);
    hold(1, 2'b00, 2'b00, 0, 0, 0);
    hold(FILT-1, 2'b01, 2'b00, 0, 0, 0);
    hold(1, 2'b00, 2'b00, 0, 0, 0);
    hold(FILT-1, 2'b00, 2'b10, 0, 0, 0);
    hold(1, 2'b00, 2'b00, 0, 0, 0);
    hold(FILT-1, 2'b00, 2'b00, 1, 0, 0);
    hold(2, 2'b00, 2'b00, 0, 0, 0);

    // R2: left supply-side run of exactly FILT
    cur_req = "R2";
    hold(FILT, 2'b01, 2'b00, 0, 0, 0);
    // R6: stays set after release
    cur_req = "R6";
    hold(8, 2'b00, 2'b00, 0, 0, 0);

    // R7: sleep clears, and holds clear under live inputs
    cur_req = "R7";
    hold(2, 2'b00, 2'b00, 0, 1, 0);
    hold(2*FILT, 2'b11, 2'b11, 1, 1, 0);
    hold(2, 2'b00, 2'b00, 0, 0, 0);

    // R3 and R11: right ground-side run leaves left flag clear
    cur_req = "R3";
    hold(FILT, 2'b00, 2'b10, 0, 0, 0);
    cur_req = "R11";
    hold(3, 2'b00, 2'b00, 0, 0, 0);
    hold(FILT, 2'b00, 2'b01, 0, 0, 0);
    hold(2, 2'b00, 2'b00, 0, 0, 0);
    cur_req = "R7";
    hold(1, 2'b00, 2'b00, 0, 1, 0);
    hold(2, 2'b00, 2'b00, 0, 0, 0);

    // R8: mute gates overcurrent; run restarts after mute falls
    cur_req = "R8";
    hold(2*FILT, 2'b10, 2'b01, 0, 0, 1);
    hold(FILT+2, 2'b10, 2'b00, 0, 0, 0);
    hold(2, 2'b00, 2'b00, 0, 1, 0);
    hold(FILT-2, 2'b00, 2'b01, 0, 0, 0);
    hold(1, 2'b00, 2'b01, 0, 0, 1);
    hold(FILT-1, 2'b00, 2'b01, 0, 0, 0);
    hold(2, 2'b00, 2'b01, 0, 0, 0);
    hold(1, 2'b00, 2'b00, 0, 1, 0);

    // R9: thermal works in mute
    cur_req = "R9";
    hold(FILT+2, 2'b00, 2'b00, 1, 0, 1);
    hold(2, 2'b00, 2'b00, 0, 0, 0);
    hold(1, 2'b00, 2'b00, 0, 1, 0);

    // R10: thermal cycles during sleep do not count
    cur_req = "R10";
    hold(FILT-1, 2'b00, 2'b00, 1, 1, 0);
    hold(FILT-1, 2'b00, 2'b00, 1, 0, 0);
    hold(3, 2'b00, 2'b00, 1, 0, 0);

    // R5 / R6: plain thermal qualify then hold
    cur_req = "R5";
    hold(1, 2'b00, 2'b00, 0, 1, 0);
    hold(FILT, 2'b00, 2'b00, 1, 0, 0);
    cur_req = "R6";
    hold(5, 2'b00, 2'b00, 0, 0, 0);

    drain();
    if (exp_q.size() != 0) begin
      n_fail++;
      $display("FAIL R1: monitor left %0d items, expected 0", exp_q.size());
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_fail++;
      $display("FAIL R1: watchdog expired, actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule